// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address for a 32-bit fetch unit. Every cycle it takes the current fetch address and reads the one entry selected by address bits [8:2]. It compares that entry's tag with the upper address bits and with bit 1. If a valid entry matches and its two-bit history leans taken, it offers the stored branch target as the next fetch address. The prediction is registered and appears one cycle after the fetch address is presented.

A separate update port receives the resolved outcome of each executed branch. A taken branch that misses claims its entry and starts in the weakly-taken state. A branch that hits moves its saturating history one step toward the actual outcome. An enable input gates both prediction and training. An invalidate input clears every entry at once and is meant to be pulsed whenever the instruction cache is invalidated. Because the tag includes address bit 1, entries also serve 16-bit compressed-mode branches, and targets are kept at halfword granularity.

Top module: `br_target_buf`

## Requirements
- R1: The entry is selected by address bits [8:2], giving 128 entries. The prediction outputs are registered: they show the result for the fetch address sampled at the preceding rising clock edge.
- R2: An entry hits only when it is valid and its stored tag equals the fetch address bits [31:9] and bit [1], all 24 bits of them. Any single mismatching bit, including bit 1, is a miss.
- R3: When predicting taken, `pred_target_o` equals {stored target bits [31:1], 1'b0}. When not predicting taken, `pred_target_o` is zero.
- R4: The history is encoded strongly-not-taken = 2'b00, weakly-not-taken = 2'b01, weakly-taken = 2'b10 and strongly-taken = 2'b11. A taken outcome steps toward 2'b11 and a not-taken outcome steps toward 2'b00, saturating at both ends. Taken is predicted only on a hit with history 2'b10 or 2'b11.
- R5: A taken update that misses writes the tag, the target bits [31:1] and history 2'b10 into its entry and marks it valid, replacing any previous occupant. A not-taken update that misses changes nothing.
- R6: An update that hits changes only the entry's history. Its tag and target stay as they were.
- R7: After reset all entries are invalid and both outputs are zero. While `enable_i` is low, no prediction is made and the update port is ignored.
- R8: A pulse on `inval_i` clears the valid bits of all entries. An update applied in the same cycle is discarded.
- R9: When an update and a lookup select the same entry in the same cycle, the lookup returns the prediction from the entry's state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Buffer enable; low disables prediction and training |
| inval_i | input | 1 | Clear all entries |
| fetch_pc_i | input | 32 | Current fetch address to look up |
| upd_valid_i | input | 1 | Update port carries a resolved branch this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_target_i | input | 32 | Resolved branch target (bit 0 ignored) |
| pred_taken_o | output | 1 | Next fetch should be redirected |
| pred_target_o | output | 32 | Predicted next fetch address |

## Verification
A lookup and an update can select the same entry in the same clock edge. The bench provokes this by driving a fetch address and a not-taken update with equal bits [8:2] in one cycle. It then judges that the registered prediction still shows the weakly-taken state from before the update, and that the following lookup shows the weakened state. The same-cycle clash of invalidate and allocation is also driven, and the bench judges that the entry does not survive.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        HIST_SN = 2'b00,
        HIST_WN = 2'b01,
        HIST_WT = 2'b10,
        HIST_ST = 2'b11
    } hist_e;

    // one saturating step toward the observed outcome
    function automatic hist_e hist_step(input hist_e h, input logic taken);
        hist_e r;
        r = h;
        if (taken) begin
            if (h != HIST_ST) r = hist_e'(h + 2'd1);
        end else begin
            if (h != HIST_SN) r = hist_e'(h - 2'd1);
        end
        return r;
    endfunction

    function automatic logic hist_predicts(input hist_e h);
        return h[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 24,
    parameter int TGT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    // lookup read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    output hist_e            rd_hist,
    // update read port
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_valid,
    output logic [TAG_W-1:0] up_tag,
    output hist_e            up_hist,
    // write port (uses up_idx)
    input  logic             wr_en,
    input  logic             wr_alloc,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  hist_e            wr_hist
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_mem  [ENTRIES];
    logic [TGT_W-1:0]   tgt_mem  [ENTRIES];
    hist_e              hist_mem [ENTRIES];

    always_comb begin
        valid_d = valid_q;
        if (clr_all) begin
            valid_d = '0;
        end else if (wr_alloc) begin
            valid_d[up_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // payload arrays need no reset: valid bits guard them
    always_ff @(posedge clk) begin
        if (wr_en) begin
            hist_mem[up_idx] <= wr_hist;
            if (wr_alloc) begin
                tag_mem[up_idx] <= wr_tag;
                tgt_mem[up_idx] <= wr_tgt;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_tgt   = tgt_mem[rd_idx];
    assign rd_hist  = hist_mem[rd_idx];

    assign up_valid = valid_q[up_idx];
    assign up_tag   = tag_mem[up_idx];
    assign up_hist  = hist_mem[up_idx];

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             entry_valid,
    input  logic [TAG_W-1:0] entry_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  hist_e            entry_hist,
    output logic             hit,
    output logic             lean_taken
);
    assign hit        = entry_valid && (entry_tag == probe_tag);
    assign lean_taken = hit && hist_predicts(entry_hist);
endmodule

// File: rtl/br_target_buf.sv
module br_target_buf
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 7,
    parameter int IDX_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              inval_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_target_o
);
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB + 1;
    localparam int TGT_W   = ADDR_W - 1;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] target;
    } pred_t;

    pred_t out_d, out_q;

    logic [IDX_W-1:0] look_idx, up_idx;
    logic [TAG_W-1:0] look_tag, up_tag_probe;

    logic             rd_valid, up_valid;
    logic [TAG_W-1:0] rd_tag, up_tag;
    logic [TGT_W-1:0] rd_tgt;
    hist_e            rd_hist, up_hist;

    logic  look_hit, look_taken;
    logic  up_hit, up_lean_unused;
    logic  upd_go, wr_en, wr_alloc;
    hist_e wr_hist;

    logic  unused_bits;
    assign unused_bits = ^{fetch_pc_i[0], upd_pc_i[0], upd_target_i[0], look_hit};

    assign look_idx     = fetch_pc_i[TAG_LSB-1:IDX_LSB];
    assign look_tag     = {fetch_pc_i[ADDR_W-1:TAG_LSB], fetch_pc_i[1]};
    assign up_idx       = upd_pc_i[TAG_LSB-1:IDX_LSB];
    assign up_tag_probe = {upd_pc_i[ADDR_W-1:TAG_LSB], upd_pc_i[1]};

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (inval_i),
        .rd_idx   (look_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_hist  (rd_hist),
        .up_idx   (up_idx),
        .up_valid (up_valid),
        .up_tag   (up_tag),
        .up_hist  (up_hist),
        .wr_en    (wr_en),
        .wr_alloc (wr_alloc),
        .wr_tag   (up_tag_probe),
        .wr_tgt   (upd_target_i[ADDR_W-1:1]),
        .wr_hist  (wr_hist)
    );

    btb_match #(.TAG_W(TAG_W)) u_look_cmp (
        .entry_valid (rd_valid),
        .entry_tag   (rd_tag),
        .probe_tag   (look_tag),
        .entry_hist  (rd_hist),
        .hit         (look_hit),
        .lean_taken  (look_taken)
    );

    btb_match #(.TAG_W(TAG_W)) u_upd_cmp (
        .entry_valid (up_valid),
        .entry_tag   (up_tag),
        .probe_tag   (up_tag_probe),
        .entry_hist  (up_hist),
        .hit         (up_hit),
        .lean_taken  (up_lean_unused)
    );

    // training: invalidate wins, disabled buffer ignores updates
    assign upd_go   = upd_valid_i && enable_i && !inval_i;
    assign wr_alloc = upd_go && !up_hit && upd_taken_i;
    assign wr_en    = upd_go && (up_hit || upd_taken_i);
    assign wr_hist  = up_hit ? hist_step(up_hist, upd_taken_i) : HIST_WT;

    always_comb begin
        out_d        = '0;
        out_d.taken  = enable_i && look_taken;
        if (out_d.taken) out_d.target = {rd_tgt, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pred_taken_o  = out_q.taken;
    assign pred_target_o = out_q.target;

endmodule

module btb_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              inval_i,
    input logic              pred_taken_o,
    input logic [ADDR_W-1:0] pred_target_o
);
    // R7
    disabled_no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable_i) |-> !pred_taken_o);

    // R8
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inval_i, 2) |-> !pred_taken_o);

    // R3
    idle_target_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken_o |-> (pred_target_o == '0));

    // R3
    target_halfword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> (pred_target_o[0] == 1'b0));

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !pred_taken_o);
endmodule

bind br_target_buf btb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .inval_i       (inval_i),
    .pred_taken_o  (pred_taken_o),
    .pred_target_o (pred_target_o)
);

// File: tb/br_target_buf_test.sv
module br_target_buf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        inval_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [31:0] upd_target_i = '0;
    logic        pred_taken_o;
    logic [31:0] pred_target_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    br_target_buf uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .inval_i(inval_i),
        .fetch_pc_i(fetch_pc_i), .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
        .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i),
        .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o)
    );

    // reference model built from the requirements
    bit          m_valid [128];
    logic [23:0] m_tag   [128];
    logic [30:0] m_tgt   [128];
    logic [1:0]  m_hist  [128];

    function automatic logic [23:0] tag_of(input logic [31:0] pc);
        return {pc[31:9], pc[1]};
    endfunction

    function automatic logic m_hit(input logic [31:0] pc);
        return m_valid[pc[8:2]] && (m_tag[pc[8:2]] == tag_of(pc));
    endfunction

    function automatic logic m_taken(input logic [31:0] pc);
        return enable_i && m_hit(pc) && m_hist[pc[8:2]][1];
    endfunction

    function automatic logic [31:0] m_target(input logic [31:0] pc);
        return m_taken(pc) ? {m_tgt[pc[8:2]], 1'b0} : 32'h0;
    endfunction

    task automatic m_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        int i;
        i = int'(pc[8:2]);
        if (!enable_i) return;
        if (m_hit(pc)) begin
            if (tk && m_hist[i] != 2'b11) m_hist[i] = m_hist[i] + 2'd1;
            if (!tk && m_hist[i] != 2'b00) m_hist[i] = m_hist[i] - 2'd1;
        end else if (tk) begin
            m_valid[i] = 1'b1;
            m_tag[i]   = tag_of(pc);
            m_tgt[i]   = tg[31:1];
            m_hist[i]  = 2'b10;
        end
    endtask

    task automatic check(input string req, input logic at, input logic [31:0] ag,
                         input logic et, input logic [31:0] eg);
        checks++;
        if (at !== et || ag !== eg) begin
            fails++;
            $display("FAIL %s: got taken=%0b target=%h, expected taken=%0b target=%h",
                     req, at, ag, et, eg);
        end
    endtask

    // present a fetch address, check the registered prediction one edge later
    task automatic lookup(input string req, input logic [31:0] pc);
        logic et;
        logic [31:0] eg;
        @(negedge clk);
        fetch_pc_i = pc;
        et = m_taken(pc);
        eg = m_target(pc);
        @(negedge clk);
        check(req, pred_taken_o, pred_target_o, et, eg);
    endtask

    task automatic update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        @(negedge clk);
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
        m_update(pc, tk, tg);
        @(negedge clk);
        upd_valid_i = 1'b0;
    endtask

    task automatic invalidate();
        @(negedge clk);
        inval_i = 1'b1;
        for (int i = 0; i < 128; i++) m_valid[i] = 1'b0;
        @(negedge clk);
        inval_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 reset outputs", pred_taken_o, pred_target_o, 1'b0, 32'h0);
        update(32'h0000_1000, 1'b1, 32'h0000_2000);   // ignored while disabled
        enable_i = 1'b1;
        lookup("R7 update ignored when disabled", 32'h0000_1000);
        check("R7 no entry after disabled update", pred_taken_o, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic t_alloc();
        update(32'h1234_5678, 1'b1, 32'hABCD_0001);
        lookup("R5 allocate, R3 target", 32'h1234_5678);
        check("R1 R4 new entry predicts taken", pred_taken_o, pred_target_o, 1'b1, 32'hABCD_0000);
        update(32'h0000_4100, 1'b0, 32'h0000_5000);
        lookup("R5 not-taken miss no allocation", 32'h0000_4100);
        update(32'h1234_5678, 1'b1, 32'h7777_7770);
        lookup("R6 hit keeps target", 32'h1234_5678);
        check("R6 target unchanged", pred_taken_o, pred_target_o, 1'b1, 32'hABCD_0000);
    endtask

    task automatic t_history();
        logic [31:0] pc;
        pc = 32'h0040_0020;
        update(pc, 1'b1, 32'h0040_0800);                     // WT
        update(pc, 1'b0, 0); lookup("R4 WT->WN", pc);
        update(pc, 1'b0, 0); lookup("R4 WN->SN", pc);
        update(pc, 1'b0, 0); update(pc, 1'b0, 0);
        lookup("R4 saturate at SN", pc);
        update(pc, 1'b1, 0); lookup("R4 SN->WN", pc);
        update(pc, 1'b1, 0); lookup("R4 WN->WT", pc);
        update(pc, 1'b1, 0); update(pc, 1'b1, 0); update(pc, 1'b1, 0);
        update(pc, 1'b0, 0); lookup("R4 saturate at ST", pc);
        check("R4 ST then NT still taken", pred_taken_o, 32'h0, 1'b1, 32'h0);
    endtask

    task automatic t_tag();
        update(32'h0080_0104, 1'b1, 32'h0080_0200);
        lookup("R2 bit1 mismatch misses", 32'h0080_0106);
        lookup("R2 high bit mismatch misses", 32'h8080_0104);
        lookup("R1 other index misses", 32'h0080_0108);
        update(32'h0080_0106, 1'b1, 32'h0090_0000);          // same index, bit1 set
        lookup("R5 replaced entry hits", 32'h0080_0106);
        lookup("R5 previous occupant gone", 32'h0080_0104);
        check("R5 replacement evicts", pred_taken_o, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic t_enable_inval();
        update(32'h0000_3000, 1'b1, 32'h0000_3800);
        enable_i = 1'b0;
        lookup("R7 disabled no prediction", 32'h0000_3000);
        enable_i = 1'b1;
        lookup("R7 re-enabled predicts", 32'h0000_3000);
        invalidate();
        lookup("R8 invalidate clears", 32'h0000_3000);
        lookup("R8 invalidate clears other", 32'h1234_5678);
        // invalidate and allocation in one cycle: invalidate wins
        @(negedge clk);
        inval_i = 1'b1;
        upd_valid_i = 1'b1; upd_pc_i = 32'h0000_3000; upd_taken_i = 1'b1; upd_target_i = 32'h44;
        for (int i = 0; i < 128; i++) m_valid[i] = 1'b0;
        @(negedge clk);
        inval_i = 1'b0; upd_valid_i = 1'b0;
        lookup("R8 same-cycle update discarded", 32'h0000_3000);
    endtask

    task automatic t_collide();
        logic [31:0] pc;
        logic et;
        logic [31:0] eg;
        pc = 32'h0500_0044;
        update(pc, 1'b1, 32'h0500_1000);                     // WT
        @(negedge clk);
        fetch_pc_i = pc;
        et = m_taken(pc);
        eg = m_target(pc);
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = 1'b0; upd_target_i = 0;
        m_update(pc, 1'b0, 0);
        @(negedge clk);
        upd_valid_i = 1'b0;
        check("R9 same-cycle lookup sees old state", pred_taken_o, pred_target_o, et, eg);
        lookup("R9 following lookup sees new state", pc);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_hist[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_history();
        t_tag();
        t_enable_inval();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule